// File: doc/BRIEF.md
# Write-Allocate Limit Decision Unit

This block decides, for every pending store that missed the level-one data cache, whether the cache should allocate a line for it. It holds a 64-bit write-handling control register. Software programs that register with an allocation ceiling: a 7-bit count of 4 Mbyte units, normally set to the amount of installed memory. The register also carries an enable for the 1 Mbyte window that starts at 15 Mbytes. Stores below the ceiling allocate. Stores at or above it do not.

Two hint inputs come from neighbouring logic. One reports that the store targets a cacheable page. The other reports that the store targets a sector already present in the cache. Either hint forces allocation, whatever the ceiling says. The unit answers each valid request with a registered decision one clock later. It has no cache arrays, no line-fill logic and no hint generation of its own.

Top module: `wralloc_limit_unit`

## Requirements
- R1: After reset the control register reads back as all zeros, and `dec_valid` and `dec_alloc` are 0.
- R2: A register write stores bits 9 down to 1 and returns them on `cfg_rdata` from the following cycle. Every other bit always reads 0, whatever was written. With no write, the read value holds.
- R3: Bit 8 of the register is stored and read back, but its value never changes a decision.
- R4: The ceiling is the field in bits 7 down to 1 (bit 1 is its least significant bit) multiplied by 4 Mbytes. A request with an address strictly below the ceiling allocates. For example, field value 8 gives a 32 Mbyte ceiling, so address 0x01FFFFFF allocates.
- R5: With no hint asserted, a request at or above the ceiling does not allocate. An address of 512 Mbytes or more never allocates through the ceiling.
- R6: A ceiling field of zero disables ceiling-based allocation for every address.
- R7: If either `hint_page` or `hint_sector` is 1 with a valid request, the request allocates, regardless of the ceiling, the window or bit 9.
- R8: When bit 9 is 0 and no hint is asserted, addresses from 0x00F00000 through 0x00FFFFFF (15 to 16 Mbytes) never allocate. When bit 9 is 1, those addresses follow the ceiling rule.
- R9: `dec_valid` is 1 exactly in the cycle after a cycle in which `req_valid` is 1. `dec_alloc` is 0 whenever `dec_valid` is 0.
- R10: A request presented in the same cycle as a register write is decided with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 64 | Data written to the control register |
| cfg_rdata | output | 64 | Current control register value |
| req_valid | input | 1 | A store that missed the cache is pending |
| req_addr | input | 32 | Physical address of the pending store |
| hint_page | input | 1 | The store targets a cacheable page |
| hint_sector | input | 1 | The store targets a sector already present |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_alloc | output | 1 | 1 means allocate a line, 0 means do not |

## Verification
The bench probes the ceiling at both edges: the last byte below 32 Mbytes and below 508 Mbytes, and the first byte at each. A comparison that is off by one, or that uses `<=`, allocates at the ceiling itself. It also sends addresses of 512 Mbytes and above, which a design that dropped the upper address bits would wrap into the allowed range. The 15-to-16 Mbyte window is probed at its first byte, its last byte and the bytes just outside it, with bit 9 both clear and set. A design with a misdecoded window would either allocate inside it or refuse allocation at 16 Mbytes. Further tests cover a zero ceiling with and without hints, bit 8 toggling, writes of all ones that reach the reserved bits, and a request that coincides with a register write. These expose a design that lets the hints be masked, that decodes bit 8, that keeps reserved bits, or that bypasses the new value to a request in the same cycle.

// File: rtl/wral_pkg.sv
package wral_pkg;

   // Bit mask of the writable register fields: the ceiling field, the
   // stored-only control bit and the window enable.
   function automatic logic [63:0] writable_mask(input int lim_lsb,
                                                 input int lim_w,
                                                 input int keep_bit,
                                                 input int win_bit);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if ((i >= lim_lsb && i < lim_lsb + lim_w) || i == keep_bit || i == win_bit)
            m[i] = 1'b1;
      end
      return m;
   endfunction

   // Source of an allocation decision.
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_CEIL  = 2'd1,
      SRC_HINT  = 2'd2
   } alloc_src_e;

endpackage

// File: rtl/wral_cfg_reg.sv
module wral_cfg_reg #(
   parameter int REG_W    = 64,
   parameter int LIM_LSB  = 1,
   parameter int LIM_W    = 7,
   parameter int KEEP_BIT = 8,
   parameter int WIN_BIT  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [LIM_W-1:0] lim,
   output logic             win_en
);
   import wral_pkg::*;

   localparam logic [63:0] FULL_MASK = writable_mask(LIM_LSB, LIM_W, KEEP_BIT, WIN_BIT);
   localparam logic [REG_W-1:0] WR_MASK = FULL_MASK[REG_W-1:0];

   logic [REG_W-1:0] q;

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (wr_en) bit_q <= wdata[b];
         end
         assign q[b] = bit_q;
      end else begin : g_rsvd
         assign q[b] = 1'b0;
      end
   end

   logic unused_rsvd;
   assign unused_rsvd = ^(wdata & ~WR_MASK);

   assign rdata  = q;
   assign lim    = q[LIM_LSB +: LIM_W];
   assign win_en = q[WIN_BIT];

   assert_win_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rdata[WIN_BIT] == $past(wdata[WIN_BIT]));
   assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rdata));

endmodule

// File: rtl/wral_limit_cmp.sv
module wral_limit_cmp #(
   parameter int ADDR_W        = 32,
   parameter int LIM_W         = 7,
   parameter int GRAN_LOG2     = 22,
   parameter int WIN_GRAN_LOG2 = 20,
   parameter int WIN_IDX       = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LIM_W-1:0]  lim,
   input  logic              win_en,
   output logic              ceil_hit
);
   localparam int HI_W  = ADDR_W - GRAN_LOG2;
   localparam int WIN_W = ADDR_W - WIN_GRAN_LOG2;

   logic [HI_W-1:0]  addr_hi;
   logic [HI_W-1:0]  lim_ext;
   logic [WIN_W-1:0] addr_mb;
   logic             below;
   logic             in_win;

   assign addr_hi = addr[ADDR_W-1:GRAN_LOG2];
   assign addr_mb = addr[ADDR_W-1:WIN_GRAN_LOG2];

   if (HI_W == LIM_W) begin : g_ext_same
      assign lim_ext = lim;
   end else begin : g_ext_pad
      assign lim_ext = {{(HI_W-LIM_W){1'b0}}, lim};
   end

   logic unused_low;
   assign unused_low = ^addr[WIN_GRAN_LOG2-1:0];

   assign below    = addr_hi < lim_ext;
   assign in_win   = addr_mb == WIN_W'(WIN_IDX);
   assign ceil_hit = below && !(in_win && !win_en);

endmodule

// File: rtl/wral_decide.sv
module wral_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic ceil_hit,
   input  logic hint_page,
   input  logic hint_sector,
   output logic dec_valid,
   output logic dec_alloc
);
   import wral_pkg::*;

   alloc_src_e src;

   always_comb begin
      if (hint_page || hint_sector) src = SRC_HINT;
      else if (ceil_hit)            src = SRC_CEIL;
      else                          src = SRC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_alloc <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_alloc <= req_valid && (src != SRC_NONE);
      end
   end

   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid && !dec_alloc);
   assert_hint_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (hint_page || hint_sector) |=> dec_alloc);

endmodule

// File: rtl/wralloc_limit_unit.sv
module wralloc_limit_unit #(
   parameter int ADDR_W        = 32,
   parameter int REG_W         = 64,
   parameter int LIM_LSB       = 1,
   parameter int LIM_W         = 7,
   parameter int KEEP_BIT      = 8,
   parameter int WIN_BIT       = 9,
   parameter int GRAN_LOG2     = 22,
   parameter int WIN_GRAN_LOG2 = 20,
   parameter int WIN_IDX       = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              hint_page,
   input  logic              hint_sector,
   output logic              dec_valid,
   output logic              dec_alloc
);
   localparam int HI_W  = ADDR_W - GRAN_LOG2;
   localparam int WIN_W = ADDR_W - WIN_GRAN_LOG2;

   if (REG_W > 64) begin : g_bad_reg
      $error("REG_W must not exceed 64");
   end
   if (LIM_LSB + LIM_W > REG_W || KEEP_BIT >= REG_W || WIN_BIT >= REG_W) begin : g_bad_field
      $error("register fields exceed REG_W");
   end
   if (HI_W < LIM_W) begin : g_bad_gran
      $error("address too narrow for the ceiling field");
   end
   if (WIN_GRAN_LOG2 > GRAN_LOG2 || WIN_GRAN_LOG2 < 1) begin : g_bad_win
      $error("window granule must be finer than the ceiling granule");
   end

   logic [LIM_W-1:0] cfg_lim;
   logic             cfg_win_en;
   logic             ceil_hit;

   wral_cfg_reg #(
      .REG_W(REG_W), .LIM_LSB(LIM_LSB), .LIM_W(LIM_W),
      .KEEP_BIT(KEEP_BIT), .WIN_BIT(WIN_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .lim(cfg_lim), .win_en(cfg_win_en)
   );

   wral_limit_cmp #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_LOG2(GRAN_LOG2),
      .WIN_GRAN_LOG2(WIN_GRAN_LOG2), .WIN_IDX(WIN_IDX)
   ) u_cmp (
      .addr(req_addr), .lim(cfg_lim), .win_en(cfg_win_en), .ceil_hit(ceil_hit)
   );

   wral_decide u_dec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ceil_hit(ceil_hit),
      .hint_page(hint_page), .hint_sector(hint_sector),
      .dec_valid(dec_valid), .dec_alloc(dec_alloc)
   );

   assert_at_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !hint_page && !hint_sector
      && (req_addr[ADDR_W-1:GRAN_LOG2] >= HI_W'(cfg_lim)) |=> !dec_alloc);
   assert_zero_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !hint_page && !hint_sector && (cfg_lim == '0) |=> !dec_alloc);
   assert_window_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !hint_page && !hint_sector && !cfg_win_en
      && (req_addr[ADDR_W-1:WIN_GRAN_LOG2] == WIN_W'(WIN_IDX)) |=> !dec_alloc);

endmodule

// File: tb/wralloc_limit_unit_bench.sv
`timescale 1ns/1ps
module wralloc_limit_unit_bench;

   typedef struct {
      bit    alloc;
      string req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        hint_page = 1'b0;
   logic        hint_sector = 1'b0;
   logic        dec_valid;
   logic        dec_alloc;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t sb[$];
   logic [63:0] model_reg = '0;

   always #2.5 clk = ~clk;

   wralloc_limit_unit u_wralloc_limit_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
      .hint_page(hint_page), .hint_sector(hint_sector),
      .dec_valid(dec_valid), .dec_alloc(dec_alloc)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected decision from the requirements (R4..R8).
   function automatic bit model(input logic [63:0] r, input logic [31:0] a,
                                input bit pg, input bit sc);
      logic [9:0] lim10;
      bit below, win;
      lim10 = {3'b000, r[7:1]};
      below = a[31:22] < lim10;
      win   = a[31:20] == 12'h00F;
      return pg || sc || (below && !(win && !r[9]));
   endfunction

   // Driver: caller stands at a falling edge.
   task automatic send(input logic [31:0] a, input bit pg, input bit sc, input string req);
      exp_t e;
      e.alloc = model(model_reg, a, pg, sc);
      e.req   = req;
      sb.push_back(e);
      req_valid = 1'b1; req_addr = a; hint_page = pg; hint_sector = sc;
      @(negedge clk);
      req_valid = 1'b0; hint_page = 1'b0; hint_sector = 1'b0;
   endtask

   task automatic wr(input logic [63:0] d);
      cfg_wr_en = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      model_reg = d & 64'h0000_0000_0000_03FE;
      check("R2", cfg_rdata, model_reg);
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   // Monitor: compare every decision against the scoreboard.
   always @(negedge clk) begin
      if (rst_n) begin
         if (dec_valid) begin
            if (sb.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R9: actual unexpected decision expected none");
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.req, {63'b0, dec_alloc}, {63'b0, e.alloc});
            end
         end else if (dec_alloc) begin
            n_cmp++; n_bad++;
            $display("FAIL R9: actual dec_alloc 1 without dec_valid expected 0");
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", cfg_rdata, 64'h0);
      check("R1", {62'b0, dec_valid, dec_alloc}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", cfg_rdata, 64'h0);

      // Zero ceiling: nothing allocates unless a hint is present (R6, R7).
      send(32'h0000_0000, 0, 0, "R6");
      send(32'h0010_0000, 0, 0, "R6");
      send(32'h0000_0000, 1, 0, "R7");
      send(32'h1234_5678, 0, 1, "R7");
      drain();

      // Reserved bits never stick (R2).
      wr('1);
      wr(64'h0);
      drain();
      check("R9", {63'b0, dec_valid}, 64'h0);

      // Ceiling 32 Mbytes, window disabled (R4, R5, R8).
      wr(64'h10);
      send(32'h01FF_FFFF, 0, 0, "R4");
      send(32'h0000_0000, 0, 0, "R4");
      send(32'h0200_0000, 0, 0, "R5");
      send(32'h00EF_FFFF, 0, 0, "R8");
      send(32'h00F0_0000, 0, 0, "R8");
      send(32'h00FF_FFFF, 0, 0, "R8");
      send(32'h0100_0000, 0, 0, "R8");
      send(32'h00F8_0000, 0, 1, "R7");
      drain();

      // Window enabled (R8), then bit 8 toggled (R3).
      wr(64'h210);
      send(32'h00F0_0000, 0, 0, "R8");
      send(32'h00FF_FFFF, 0, 0, "R8");
      wr(64'h110);
      send(32'h00F0_0000, 0, 0, "R3");
      send(32'h01FF_FFFF, 0, 0, "R3");
      send(32'h0200_0000, 0, 0, "R3");
      drain();

      // Largest ceiling, 508 Mbytes (R4, R5).
      wr(64'h2FE);
      send(32'h1FBF_FFFF, 0, 0, "R4");
      send(32'h1FC0_0000, 0, 0, "R5");
      send(32'h2000_0000, 0, 0, "R5");
      send(32'hFFFF_FFFF, 0, 0, "R5");
      send(32'hFFFF_FFFF, 1, 1, "R7");
      drain();

      // Request coinciding with a write uses the old value (R10).
      begin
         exp_t e;
         e.alloc = model(model_reg, 32'h1000_0000, 0, 0);
         e.req   = "R10";
         sb.push_back(e);
         req_valid = 1'b1; req_addr = 32'h1000_0000;
         cfg_wr_en = 1'b1; cfg_wdata = 64'h0;
         @(negedge clk);
         req_valid = 1'b0; cfg_wr_en = 1'b0;
         model_reg = '0;
         check("R10", cfg_rdata, 64'h0);
      end
      send(32'h1000_0000, 0, 0, "R10");
      drain();

      check("R9", sb.size(), 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         repeat (5000) @(posedge clk);
      join_any
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule